// File: doc/BRIEF.md
# Capacitive Acquisition Command Sequencer

This block steps through a short programmable list of acquisition commands that run a capacitive-voltage-divider measurement. Each command word holds the levels for the analog front end: a charge strobe, a discharge strobe, a balance-switch control, a conversion start, a 2-bit drive code for the sense pin and a 2-bit drive code for the transmit pins. It also holds a wait selector, a math-start bit with a 3-bit math sequence number, and a last-step flag. A step stays active until its wait condition is met. The condition is one of two loadable timers or the converter's end-of-conversion handshake. Then the next command is entered.

Software loads the command store, the two timer values, a repeat field and a record count, all as static register inputs. It then arms the block and triggers it. One trigger walks every record. Within each record the command list runs (repeat + 1) times back to back. The current record number is presented on an index output so that the pin multiplexer and the result storage can follow the scan. A single done pulse marks the end of the scan.

Top module: `capdiv_sequencer`

## Requirements
- R1: Out of reset, and whenever no scan is running, all strobes are low, both drive codes and the math sequence output are 0, busy is low and the record index is 0.
- R2: A trigger starts a scan only when the block is idle and armed. Arm is taken when it is sampled high while idle, and each accepted trigger uses it up. Triggers and arm pulses that arrive during a scan are ignored.
- R3: Command word bit positions are: 0 charge, 1 discharge, 2 balance, 3 convert, 5:4 sense drive (1 low, 2 high, 3 tri-state), 7:6 transmit drive (1 low, 2 high), 10:8 wait select, 11 math start, 14:12 math sequence, 15 last. For every cycle of a step, charge, discharge and both drive codes equal that step's fields.
- R4: Wait code 1 holds the step for timer A cycles and wait code 2 holds it for timer B cycles. A timer value of 0 gives one cycle.
- R5: Wait code 4 holds the step until end-of-conversion is sampled high. The next step starts on the following clock.
- R6: Any other wait code gives a one-cycle step.
- R7: A step with the convert bit set gives a convert pulse in its first cycle only, and the balance output is high for the whole step even if the balance bit is clear.
- R8: A step with the math-start bit set gives a one-cycle math-start pulse in its first cycle, with that step's math sequence number on the sequence output.
- R9: A pass ends after a step with the last flag set, or after slot 15 when no flag is set. Slots after the flagged step are never run.
- R10: Each record runs the command list (repeat + 1) times back to back.
- R11: A scan covers records 0 to record count - 1 in increasing order, with a count of 0 treated as 1. The record index output shows the record being processed.
- R12: After the last step of the last pass of the last record, busy falls and scan-done is high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_store_i | input | NSLOT*16 | Command words, slot n at bits n*16 +: 16 |
| tmr_a_i | input | TMR_W | Timer A step length |
| tmr_b_i | input | TMR_W | Timer B step length |
| rep_i | input | REP_W | Extra passes per record |
| rec_cnt_i | input | REC_W+1 | Records per scan |
| arm_i | input | 1 | Arms the next trigger |
| trig_i | input | 1 | Scan trigger |
| eoc_i | input | 1 | Converter end of conversion |
| busy_o | output | 1 | Scan in progress |
| rec_idx_o | output | REC_W | Current record |
| chrg_o | output | 1 | Charge strobe |
| dischrg_o | output | 1 | Discharge strobe |
| bal_o | output | 1 | Balance switch closed |
| conv_o | output | 1 | Conversion start pulse |
| sense_drv_o | output | 2 | Sense pin drive code |
| tx_drv_o | output | 2 | Transmit pin drive code |
| math_start_o | output | 1 | Math sequence start pulse |
| math_seq_o | output | 3 | Math sequence number |
| scan_done_o | output | 1 | Scan complete pulse |

## Verification
The bench builds the block with its default parameters: 16 command slots, 8-bit timers, a 4-bit repeat field and 5-bit record indexing. With timer values of a few cycles and an end-of-conversion responder whose latency can be set, every step length can be counted exactly. A list with no last flag reaches the slot-15 wrap. A three-record, four-pass scan shows that the record index moves only once all passes of a record are done.

// File: rtl/capdiv_pkg.sv
package capdiv_pkg;
  typedef struct packed {
    logic       last;
    logic [2:0] mseq;
    logic       mstart;
    logic [2:0] wait_sel;
    logic [1:0] tx_drv;
    logic [1:0] sense_drv;
    logic       conv;
    logic       bal;
    logic       dischrg;
    logic       chrg;
  } cmd_t;

  localparam int CMD_W = $bits(cmd_t);
  localparam logic [2:0] WAIT_TA  = 3'd1;
  localparam logic [2:0] WAIT_TB  = 3'd2;
  localparam logic [2:0] WAIT_EOC = 3'd4;
endpackage

// File: rtl/capdiv_step_timer.sv
module capdiv_step_timer
  import capdiv_pkg::*;
#(
  parameter int TMR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [2:0]       load_wait_i,
  input  logic [TMR_W-1:0] tmr_a_i,
  input  logic [TMR_W-1:0] tmr_b_i,
  input  logic             active_i,
  input  logic [2:0]       cur_wait_i,
  input  logic             eoc_i,
  output logic             done_o
);
  logic [TMR_W-1:0] cnt_q, load_val;

  always_comb begin
    unique case (load_wait_i)
      WAIT_TA: load_val = tmr_a_i;
      WAIT_TB: load_val = tmr_b_i;
      default: load_val = '0;
    endcase
  end

  // counts N-1 down to 0 so a step spans N cycles
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (load_i)                   cnt_q <= (load_val == '0) ? '0 : load_val - 1'b1;
    else if (active_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  always_comb begin
    unique case (cur_wait_i)
      WAIT_TA, WAIT_TB: done_o = active_i && (cnt_q == '0);
      WAIT_EOC:         done_o = active_i && eoc_i;
      default:          done_o = active_i;
    endcase
  end
endmodule

// File: rtl/capdiv_progress.sv
module capdiv_progress #(
  parameter int NSLOT = 16,
  parameter int REP_W = 4,
  parameter int REC_W = 5,
  localparam int SLOT_W = $clog2(NSLOT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              step_done_i,
  input  logic              last_i,
  input  logic [REP_W-1:0]  rep_i,
  input  logic [REC_W:0]    rec_cnt_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic [SLOT_W-1:0] next_slot_o,
  output logic [REC_W-1:0]  rec_o,
  output logic              scan_end_o
);
  logic [SLOT_W-1:0] slot_q;
  logic [REP_W-1:0]  pass_q;
  logic [REC_W-1:0]  rec_q;
  logic end_pass, last_pass, last_rec;

  assign end_pass   = last_i || (slot_q == SLOT_W'(NSLOT - 1));
  assign last_pass  = (pass_q == rep_i);
  assign last_rec   = ({1'b0, rec_q} + 1'b1) >= rec_cnt_i;
  assign scan_end_o = step_done_i && end_pass && last_pass && last_rec;
  assign next_slot_o = (start_i || end_pass) ? '0 : slot_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= '0;
      pass_q <= '0;
      rec_q  <= '0;
    end else if (start_i) begin
      slot_q <= '0;
      pass_q <= '0;
      rec_q  <= '0;
    end else if (step_done_i) begin
      slot_q <= next_slot_o;
      if (end_pass) begin
        if (last_pass) begin
          pass_q <= '0;
          rec_q  <= last_rec ? '0 : rec_q + 1'b1;
        end else begin
          pass_q <= pass_q + 1'b1;
        end
      end
    end
  end

  assign slot_o = slot_q;
  assign rec_o  = rec_q;
endmodule

// File: rtl/capdiv_sequencer.sv
module capdiv_sequencer
  import capdiv_pkg::*;
#(
  parameter int NSLOT = 16,
  parameter int TMR_W = 8,
  parameter int REP_W = 4,
  parameter int REC_W = 5,
  localparam int SLOT_W = $clog2(NSLOT)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NSLOT*CMD_W-1:0] cmd_store_i,
  input  logic [TMR_W-1:0]       tmr_a_i,
  input  logic [TMR_W-1:0]       tmr_b_i,
  input  logic [REP_W-1:0]       rep_i,
  input  logic [REC_W:0]         rec_cnt_i,
  input  logic                   arm_i,
  input  logic                   trig_i,
  input  logic                   eoc_i,
  output logic                   busy_o,
  output logic [REC_W-1:0]       rec_idx_o,
  output logic                   chrg_o,
  output logic                   dischrg_o,
  output logic                   bal_o,
  output logic                   conv_o,
  output logic [1:0]             sense_drv_o,
  output logic [1:0]             tx_drv_o,
  output logic                   math_start_o,
  output logic [2:0]             math_seq_o,
  output logic                   scan_done_o
);
  cmd_t cmds [NSLOT];
  cmd_t cur;
  logic busy_q, armed_q, entry_q, done_q;
  logic start, step_done, scan_end;
  logic [SLOT_W-1:0] slot, next_slot;

  for (genvar g = 0; g < NSLOT; g++) begin : g_unpack
    assign cmds[g] = cmd_t'(cmd_store_i[g*CMD_W +: CMD_W]);
  end

  assign cur   = cmds[slot];
  assign start = trig_i && armed_q && !busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      armed_q <= 1'b0;
      entry_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      if (start)                 armed_q <= 1'b0;
      else if (arm_i && !busy_q) armed_q <= 1'b1;
      if (start)                 busy_q <= 1'b1;
      else if (scan_end)         busy_q <= 1'b0;
      entry_q <= start || (step_done && !scan_end);
      done_q  <= scan_end;
    end
  end

  capdiv_progress #(.NSLOT(NSLOT), .REP_W(REP_W), .REC_W(REC_W)) i_progress (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .step_done_i (step_done),
    .last_i      (cur.last),
    .rep_i       (rep_i),
    .rec_cnt_i   (rec_cnt_i),
    .slot_o      (slot),
    .next_slot_o (next_slot),
    .rec_o       (rec_idx_o),
    .scan_end_o  (scan_end)
  );

  capdiv_step_timer #(.TMR_W(TMR_W)) i_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (start || step_done),
    .load_wait_i (cmds[next_slot].wait_sel),
    .tmr_a_i     (tmr_a_i),
    .tmr_b_i     (tmr_b_i),
    .active_i    (busy_q),
    .cur_wait_i  (cur.wait_sel),
    .eoc_i       (eoc_i),
    .done_o      (step_done)
  );

  assign busy_o       = busy_q;
  assign scan_done_o  = done_q;
  assign chrg_o       = busy_q && cur.chrg;
  assign dischrg_o    = busy_q && cur.dischrg;
  assign bal_o        = busy_q && (cur.bal || cur.conv);  // converting forces balance
  assign conv_o       = entry_q && cur.conv;
  assign math_start_o = entry_q && cur.mstart;
  assign sense_drv_o  = busy_q ? cur.sense_drv : 2'd0;
  assign tx_drv_o     = busy_q ? cur.tx_drv : 2'd0;
  assign math_seq_o   = busy_q ? cur.mseq : 3'd0;
endmodule

// File: rtl/capdiv_sequencer_chk.sv
module capdiv_sequencer_chk #(
  parameter int REC_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             trig_i,
  input logic [REC_W:0]   rec_cnt_i,
  input logic             busy_o,
  input logic [REC_W-1:0] rec_idx_o,
  input logic             chrg_o,
  input logic             dischrg_o,
  input logic             bal_o,
  input logic             conv_o,
  input logic [1:0]       sense_drv_o,
  input logic [1:0]       tx_drv_o,
  input logic             math_start_o,
  input logic             scan_done_o
);
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !chrg_o && !dischrg_o && !bal_o && !conv_o && !math_start_o
                && sense_drv_o == 2'd0 && tx_drv_o == 2'd0 && rec_idx_o == '0); // R1
  AST_START_NEEDS_TRIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(trig_i)); // R2
  AST_CONV_BAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_o |-> bal_o); // R7
  AST_MSTART_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    math_start_o |-> busy_o); // R8
  AST_REC_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> ({1'b0, rec_idx_o} < rec_cnt_i) || rec_idx_o == '0); // R11
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_done_o |-> !busy_o && $past(busy_o)); // R12
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_done_o |=> !scan_done_o); // R12
endmodule

bind capdiv_sequencer capdiv_sequencer_chk #(.REC_W(REC_W)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .trig_i       (trig_i),
  .rec_cnt_i    (rec_cnt_i),
  .busy_o       (busy_o),
  .rec_idx_o    (rec_idx_o),
  .chrg_o       (chrg_o),
  .dischrg_o    (dischrg_o),
  .bal_o        (bal_o),
  .conv_o       (conv_o),
  .sense_drv_o  (sense_drv_o),
  .tx_drv_o     (tx_drv_o),
  .math_start_o (math_start_o),
  .scan_done_o  (scan_done_o)
);

// File: tb/test_capdiv_sequencer.sv
`timescale 1ns/1ps
module test_capdiv_sequencer;
  localparam int NSLOT = 16, TMR_W = 8, REP_W = 4, REC_W = 5;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [NSLOT*16-1:0] cmd_store = '0;
  logic [TMR_W-1:0] tmr_a = '0, tmr_b = '0;
  logic [REP_W-1:0] rep = '0;
  logic [REC_W:0]   rec_cnt = 6'd1;
  logic arm = 1'b0, trig = 1'b0, eoc = 1'b0;
  logic busy, chrg, dischrg, bal, conv, mstart, done;
  logic [REC_W-1:0] rec_idx;
  logic [1:0] sense, tx;
  logic [2:0] mseq;

  always #10 clk = ~clk;

  capdiv_sequencer #(.NSLOT(NSLOT), .TMR_W(TMR_W), .REP_W(REP_W), .REC_W(REC_W)) i_capdiv_sequencer (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_store_i(cmd_store), .tmr_a_i(tmr_a), .tmr_b_i(tmr_b),
    .rep_i(rep), .rec_cnt_i(rec_cnt), .arm_i(arm), .trig_i(trig), .eoc_i(eoc),
    .busy_o(busy), .rec_idx_o(rec_idx), .chrg_o(chrg), .dischrg_o(dischrg), .bal_o(bal),
    .conv_o(conv), .sense_drv_o(sense), .tx_drv_o(tx), .math_start_o(mstart),
    .math_seq_o(mseq), .scan_done_o(done));

  int n_checks = 0, n_fail = 0;
  int n_busy, n_chrg, n_tx1, n_tx2, n_bal, n_conv, n_mst, n_done, n_s1, n_s3, n_idle_bad, last_seq;
  int conv_rec [64];
  int eoc_lat = 3, eoc_cd = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(input bit c, input bit d, input bit b, input bit cv,
      input int s, input int t, input int w, input bit ms, input int sq, input bit l);
    mk = {l, 3'(sq), ms, 3'(w), 2'(t), 2'(s), cv, b, d, c};
  endfunction

  task automatic clr_counts();
    n_busy = 0; n_chrg = 0; n_tx1 = 0; n_tx2 = 0; n_bal = 0; n_conv = 0; n_mst = 0;
    n_done = 0; n_s1 = 0; n_s3 = 0; n_idle_bad = 0; last_seq = -1;
  endtask

  always @(negedge clk) begin
    eoc <= 1'b0;
    if (eoc_cd == 1) eoc <= 1'b1;
    if (eoc_cd != 0) eoc_cd <= eoc_cd - 1;
    if (conv) eoc_cd <= eoc_lat;
    if (busy) n_busy++;
    else if (chrg || bal || sense != 0 || tx != 0 || rec_idx != 0) n_idle_bad++;
    if (chrg) n_chrg++;
    if (bal) n_bal++;
    if (tx == 2'd1) n_tx1++;
    if (tx == 2'd2) n_tx2++;
    if (sense == 2'd1) n_s1++;
    if (sense == 2'd3) n_s3++;
    if (conv) begin
      if (n_conv < 64) conv_rec[n_conv] = int'(rec_idx);
      n_conv++;
    end
    if (mstart) begin n_mst++; last_seq = int'(mseq); end
    if (done) n_done++;
  end

  task automatic fire(input bit do_arm);
    @(negedge clk); arm = do_arm;
    @(negedge clk); arm = 1'b0; trig = 1'b1;
    @(negedge clk); trig = 1'b0;
  endtask

  task automatic wait_done();
    int t = 0;
    while (n_done == 0 && t < 2000) begin @(posedge clk); t++; end
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    #1;
    chk(!busy && !chrg && !dischrg && !bal && !conv && !mstart && !done && sense == 0
        && tx == 0 && mseq == 0 && rec_idx == 0, "R1 reset state", int'(busy), 0);
  endtask

  task automatic t_basic();
    cmd_store = '0;
    cmd_store[0*16 +: 16] = mk(1,0,0,0, 1,2, 1, 0,0, 0);
    cmd_store[1*16 +: 16] = mk(0,0,1,0, 3,1, 2, 0,0, 0);
    cmd_store[2*16 +: 16] = mk(0,0,0,1, 3,0, 4, 1,5, 1);
    cmd_store[3*16 +: 16] = mk(1,1,1,0, 2,2, 0, 0,0, 0);
    tmr_a = 8'd3; tmr_b = 8'd5; rep = '0; rec_cnt = 6'd1; eoc_lat = 3;
    clr_counts();
    fire(1'b1);
    wait_done();
    chk(n_chrg == 3, "R4 timer A step length", n_chrg, 3);
    chk(n_tx2 == 3 && n_s1 == 3, "R3 step 0 drive codes", n_tx2, 3);
    chk(n_tx1 == 5, "R4 timer B step length", n_tx1, 5);
    chk(n_bal == 9, "R7 balance held through convert step", n_bal, 9);
    chk(n_s3 == 9, "R3 sense tri-state steps", n_s3, 9);
    chk(n_busy == 12, "R5 eoc step held until eoc", n_busy, 12);
    chk(n_conv == 1, "R7 single convert pulse", n_conv, 1);
    chk(n_mst == 1 && last_seq == 5, "R8 math start and sequence", last_seq, 5);
    chk(n_done == 1, "R12 one done pulse", n_done, 1);
    chk(!busy && n_idle_bad == 0, "R1 idle outputs quiet", n_idle_bad, 0);
  endtask

  task automatic t_records();
    cmd_store = '0;
    cmd_store[0*16 +: 16] = mk(0,0,0,1, 3,2, 4, 1,2, 1);
    rep = 4'd3; rec_cnt = 6'd3; eoc_lat = 1;
    clr_counts();
    fire(1'b1);
    wait_done();
    chk(n_conv == 12, "R10 passes per record", n_conv, 12);
    chk(n_mst == 12 && last_seq == 2, "R8 math starts per pass", n_mst, 12);
    for (int i = 0; i < 12; i++)
      chk(conv_rec[i] == i / 4, "R11 record index order", conv_rec[i], i / 4);
    chk(n_busy == 24, "R5 eoc latency step length", n_busy, 24);
    rep = '0; rec_cnt = '0;
    clr_counts();
    fire(1'b1);
    wait_done();
    chk(n_conv == 1 && n_done == 1, "R11 zero record count scans one", n_conv, 1);
  endtask

  task automatic t_arming();
    cmd_store = '0;
    cmd_store[0*16 +: 16] = mk(0,0,0,1, 3,2, 4, 0,0, 1);
    rep = 4'd1; rec_cnt = 6'd2; eoc_lat = 6;
    clr_counts();
    fire(1'b1);
    repeat (4) @(negedge clk);
    arm = 1'b1; trig = 1'b1;
    @(negedge clk); arm = 1'b0; trig = 1'b0;
    wait_done();
    chk(n_conv == 4 && n_done == 1, "R2 trigger during scan ignored", n_conv, 4);
    clr_counts();
    fire(1'b0);
    repeat (10) @(posedge clk);
    #1;
    chk(n_busy == 0 && n_conv == 0, "R2 trigger without arm ignored", n_busy, 0);
    clr_counts();
    fire(1'b1);
    wait_done();
    chk(n_conv == 4 && n_done == 1, "R2 rearmed trigger accepted", n_conv, 4);
  endtask

  task automatic t_slots();
    cmd_store = '0;
    for (int s = 0; s < NSLOT; s++)
      cmd_store[s*16 +: 16] = mk(0,0,0,0, 2,2, (s == 0) ? 1 : ((s % 2) ? 3 : 0), 0,0, 0);
    tmr_a = 8'd0; rep = 4'd1; rec_cnt = 6'd1;
    clr_counts();
    fire(1'b1);
    wait_done();
    chk(n_tx2 == 32 && n_busy == 32, "R9 pass wraps after slot 15, R6 one-cycle waits",
        n_busy, 32);
    cmd_store[0*16 +: 16] = mk(0,0,0,0, 2,2, 0, 0,0, 1);
    for (int s = 1; s < NSLOT; s++)
      cmd_store[s*16 +: 16] = mk(1,1,1,0, 1,1, 0, 0,0, 0);
    clr_counts();
    fire(1'b1);
    wait_done();
    chk(n_chrg == 0 && n_tx1 == 0 && n_tx2 == 2, "R9 slots after last flag skipped", n_chrg, 0);
  endtask

  initial begin
    clr_counts();
    repeat (3) @(negedge clk);
    t_reset();
    @(negedge clk); rst_ni = 1'b1;
    t_basic();
    t_records();
    t_arming();
    t_slots();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule